// File: doc/BRIEF.md
# Dual-Channel Drive Access Router

This block sits between a host that issues programmed-I/O accesses and four drive register ports arranged as two channels of two drives each. Every host access carries an address, a byte count and, for writes, data. The router compares the address against five programmable windows: a command window and a control window for each channel, plus one bus-master window. The first window that contains the address wins. From that window it derives the register offset, the kind of register and the channel.

For the command and control windows, each channel keeps a drive-select bit. The bit is loaded whenever the host writes the select register. The router sends the access to drive `2*channel + select`. When the host accesses the 16-bit data register with four bytes, the router makes two back-to-back 16-bit drive accesses, low half first, and joins the two read halves into one word. Accesses to the bus-master window go to a separate register port, together with the channel that the offset selects.

The window base addresses are programmed through a small write port. The window sizes are static inputs. A separate enable input can switch off I/O decode as a whole.

Top module: `drive_access_router`

## Requirements
- R1: Windows are checked in the order primary command (index 0), primary control (1), secondary command (2), secondary control (3), bus-master (4). Window n covers `base_n <= addr < base_n + size_n`. The lowest-index window that holds the address decides the access, and the offset is `addr - base`.
- R2: In the bus-master window, an offset below `BM_SPLIT` (8) is reported with `bm_chan = 0`, and any other offset with `bm_chan = 1`. Bus-master accesses of 1, 2 or 4 bytes make exactly one `bm_req` pulse. The host read data returned is `bm_rdata`.
- R3: A valid write to offset `SEL_OFF` (6) of a command window loads that channel's select bit from bit 4 of the written data. Both select bits are 0 after reset. The write is also forwarded to the newly selected drive.
- R4: The target drive index is `2*channel + select`, with the primary channel as 0. `d_req` carries at most one set bit, and that bit is the target drive.
- R5: The data register is offset 0 of a command window. A 2-byte access there makes one drive access. A 4-byte access makes two drive accesses on consecutive cycles: the first carries `h_wdata[15:0]` and the second carries `h_wdata[31:16]`. A 4-byte read returns `{second, first}`. A 1-byte read returns the low byte, zero-extended.
- R6: Any other register in a command or control window accepts only 1-byte accesses. The data register accepts only 2 or 4 bytes. A byte count outside these rules, or a bus-master count other than 1, 2 or 4, raises `h_err`, makes no drive or bus-master access and leaves the select bits unchanged.
- R7: When the target drive's `d_present` bit is 0, a read returns zero and a write is dropped. Neither makes a drive access.
- R8: While `io_en` is low, every access completes one cycle after acceptance. It returns zero, has no error, makes no access and does not change the select bits.
- R9: A base address is loaded by `bar_wr` with `bar_idx` equal to the window index, and only when `bar_val` is non-zero. All bases are 0 after reset.
- R10: An address that hits no window raises `h_err` and returns zero, with no access.
- R11: `h_done` is a one-cycle pulse. It comes 1 cycle after acceptance when no access is made, 2 cycles after acceptance for one access, and 3 cycles after acceptance for a split access. A request is accepted only when the router is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | I/O decode enable |
| bar_wr | input | 1 | Base address write strobe |
| bar_idx | input | 3 | Window index for the base write |
| bar_val | input | AW | Base address value |
| win_size | input | 5*AW | Window sizes, window n at bits [n*AW +: AW] |
| h_req | input | 1 | Host access request (one cycle) |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | AW | Host address |
| h_size | input | 3 | Byte count (1, 2 or 4) |
| h_wdata | input | 2*DW | Host write data |
| h_done | output | 1 | Access complete pulse |
| h_err | output | 1 | Access error, valid with h_done |
| h_rdata | output | 2*DW | Host read data, valid with h_done |
| d_present | input | 4 | Drive present flags |
| d_req | output | 4 | Per-drive access strobe |
| d_wr | output | 1 | Drive access is a write |
| d_blk | output | 1 | 0 command register, 1 control register |
| d_off | output | OW | Drive register offset |
| d_wdata | output | DW | Drive write data |
| d_rdata | input | 4*DW | Drive read data, drive n at [n*DW +: DW] |
| bm_req | output | 1 | Bus-master register access strobe |
| bm_wr | output | 1 | Bus-master access is a write |
| bm_chan | output | 1 | Channel chosen by the bus-master offset |
| bm_off | output | OW | Bus-master register offset |
| bm_size | output | 3 | Bus-master byte count |
| bm_wdata | output | 2*DW | Bus-master write data |
| bm_rdata | input | 2*DW | Bus-master read data |

## Verification
The hardest case to reach is a select-register write that changes the drive selection in the same access that is forwarded. Checking it needs the access to land at exactly the select offset with a 1-byte count, with a present drive on the new side. The stimulus targets that offset directly. It also biases random accesses toward the window edges and the data offset, so that select changes, split accesses, size errors and absent drives are interleaved. Window priority is forced in a directed step by moving one base into the span of an earlier window.

// File: rtl/dar_pkg.sv
package dar_pkg;
  localparam int NWIN = 5;
  localparam int WIN_BM = 4;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BM   = 2'd1,
    S_LO   = 2'd2,
    S_HI   = 2'd3
  } st_e;
endpackage

// File: rtl/dar_base_bank.sv
module dar_base_bank #(
  parameter int AW = 16,
  parameter int NW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bar_wr,
  input  logic [2:0]      bar_idx,
  input  logic [AW-1:0]   bar_val,
  output logic [NW*AW-1:0] bases
);
  for (genvar i = 0; i < NW; i++) begin : g_base
    always_ff @(posedge clk) begin
      if (rst)
        bases[i*AW +: AW] <= '0;
      else if (bar_wr && bar_idx == 3'(i) && bar_val != '0)
        bases[i*AW +: AW] <= bar_val;
    end
  end
endmodule

// File: rtl/dar_win_decode.sv
module dar_win_decode #(
  parameter int AW = 16,
  parameter int NW = 5
) (
  input  logic [AW-1:0]    addr,
  input  logic [NW*AW-1:0] bases,
  input  logic [NW*AW-1:0] sizes,
  output logic             hit,
  output logic [2:0]       win,
  output logic [AW-1:0]    off
);
  logic [NW-1:0] inwin;

  for (genvar i = 0; i < NW; i++) begin : g_cmp
    logic [AW:0] lo_b, hi_b;
    assign lo_b = {1'b0, bases[i*AW +: AW]};
    assign hi_b = lo_b + {1'b0, sizes[i*AW +: AW]};
    assign inwin[i] = ({1'b0, addr} >= lo_b) && ({1'b0, addr} < hi_b);
  end

  // lowest index wins: scan from the top so earlier windows overwrite
  always_comb begin
    hit = 1'b0;
    win = '0;
    off = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (inwin[i]) begin
        hit = 1'b1;
        win = 3'(i);
        off = addr - bases[i*AW +: AW];
      end
    end
  end
endmodule

// File: rtl/dar_sel_bits.sv
module dar_sel_bits (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  logic       chan,
  input  logic       bitv,
  output logic [1:0] sel
);
  for (genvar c = 0; c < 2; c++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)
        sel[c] <= 1'b0;
      else if (upd && chan == 1'(c))
        sel[c] <= bitv;
    end
  end
endmodule

// File: rtl/drive_access_router.sv
module drive_access_router #(
  parameter int AW       = 16,
  parameter int OW       = 4,
  parameter int DW       = 16,
  parameter int DATA_OFF = 0,
  parameter int SEL_OFF  = 6,
  parameter int SEL_BIT  = 4,
  parameter int BM_SPLIT = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     io_en,
  input  logic                     bar_wr,
  input  logic [2:0]               bar_idx,
  input  logic [AW-1:0]            bar_val,
  input  logic [dar_pkg::NWIN*AW-1:0] win_size,
  input  logic                     h_req,
  input  logic                     h_wr,
  input  logic [AW-1:0]            h_addr,
  input  logic [2:0]               h_size,
  input  logic [2*DW-1:0]          h_wdata,
  output logic                     h_done,
  output logic                     h_err,
  output logic [2*DW-1:0]          h_rdata,
  input  logic [3:0]               d_present,
  output logic [3:0]               d_req,
  output logic                     d_wr,
  output logic                     d_blk,
  output logic [OW-1:0]            d_off,
  output logic [DW-1:0]            d_wdata,
  input  logic [4*DW-1:0]          d_rdata,
  output logic                     bm_req,
  output logic                     bm_wr,
  output logic                     bm_chan,
  output logic [OW-1:0]            bm_off,
  output logic [2:0]               bm_size,
  output logic [2*DW-1:0]          bm_wdata,
  input  logic [2*DW-1:0]          bm_rdata
);
  import dar_pkg::*;
  localparam int HW = 2 * DW;

  st_e st;
  logic [NWIN*AW-1:0] bases;
  logic               hit;
  logic [2:0]         win;
  logic [AW-1:0]      off_c;
  logic [1:0]         sel;

  logic          accept, is_bm, is_cmd, is_data, sz_ok, chan_c;
  logic          sel_upd, sel_now;
  logic [1:0]    idx_c, idx_q;
  logic          wide_q, byte_q;
  logic [DW-1:0] hi_q, lo_q, slice;

  dar_base_bank #(.AW(AW), .NW(NWIN)) u_bank (
    .clk(clk), .rst(rst), .bar_wr(bar_wr), .bar_idx(bar_idx),
    .bar_val(bar_val), .bases(bases)
  );

  dar_win_decode #(.AW(AW), .NW(NWIN)) u_dec (
    .addr(h_addr), .bases(bases), .sizes(win_size),
    .hit(hit), .win(win), .off(off_c)
  );

  dar_sel_bits u_sel (
    .clk(clk), .rst(rst), .upd(sel_upd), .chan(chan_c),
    .bitv(h_wdata[SEL_BIT]), .sel(sel)
  );

  always_comb begin
    accept  = (st == S_IDLE) && h_req;
    is_bm   = (win == 3'(WIN_BM));
    chan_c  = is_bm ? (off_c >= AW'(BM_SPLIT)) : win[1];
    is_cmd  = hit && !is_bm && !win[0];
    is_data = is_cmd && (off_c == AW'(DATA_OFF));
    if (is_data)
      sz_ok = (h_size == 3'd2) || (h_size == 3'd4);
    else if (is_bm)
      sz_ok = (h_size == 3'd1) || (h_size == 3'd2) || (h_size == 3'd4);
    else
      sz_ok = (h_size == 3'd1);
    sel_upd = accept && io_en && hit && sz_ok && is_cmd && h_wr &&
              (off_c == AW'(SEL_OFF));
    sel_now = sel_upd ? h_wdata[SEL_BIT] : sel[chan_c];
    idx_c   = {chan_c, sel_now};
    slice   = d_rdata[idx_q*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      h_done   <= 1'b0;
      h_err    <= 1'b0;
      h_rdata  <= '0;
      d_req    <= '0;
      d_wr     <= 1'b0;
      d_blk    <= 1'b0;
      d_off    <= '0;
      d_wdata  <= '0;
      bm_req   <= 1'b0;
      bm_wr    <= 1'b0;
      bm_chan  <= 1'b0;
      bm_off   <= '0;
      bm_size  <= '0;
      bm_wdata <= '0;
      idx_q    <= '0;
      wide_q   <= 1'b0;
      byte_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      h_done <= 1'b0;
      h_err  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (!io_en) begin
              h_done  <= 1'b1;
              h_rdata <= '0;
            end else if (!hit || !sz_ok) begin
              h_done  <= 1'b1;
              h_err   <= 1'b1;
              h_rdata <= '0;
            end else if (is_bm) begin
              bm_req   <= 1'b1;
              bm_wr    <= h_wr;
              bm_chan  <= chan_c;
              bm_off   <= off_c[OW-1:0];
              bm_size  <= h_size;
              bm_wdata <= h_wdata;
              st       <= S_BM;
            end else if (!d_present[idx_c]) begin
              h_done  <= 1'b1;
              h_rdata <= '0;
            end else begin
              d_req   <= 4'(1) << idx_c;
              d_wr    <= h_wr;
              d_blk   <= win[0];
              d_off   <= off_c[OW-1:0];
              d_wdata <= h_wdata[DW-1:0];
              hi_q    <= h_wdata[HW-1:DW];
              wide_q  <= (h_size == 3'd4);
              byte_q  <= (h_size == 3'd1);
              idx_q   <= idx_c;
              st      <= S_LO;
            end
          end
        end
        S_BM: begin
          bm_req  <= 1'b0;
          h_rdata <= bm_rdata;
          h_done  <= 1'b1;
          st      <= S_IDLE;
        end
        S_LO: begin
          if (wide_q) begin
            lo_q    <= slice;
            d_wdata <= hi_q;
            st      <= S_HI;
          end else begin
            d_req   <= '0;
            h_done  <= 1'b1;
            h_rdata <= byte_q ? HW'(slice[7:0]) : HW'(slice);
            st      <= S_IDLE;
          end
        end
        default: begin
          d_req   <= '0;
          h_done  <= 1'b1;
          h_rdata <= {slice, lo_q};
          st      <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dar_checker.sv
module dar_checker #(
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             io_en,
  input logic             h_req,
  input dar_pkg::st_e     st,
  input logic [3:0]       d_req,
  input logic             bm_req,
  input logic             h_done,
  input logic             h_err,
  input logic [2*DW-1:0]  h_rdata
);
  p_req_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(d_req));

  p_io_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (st == dar_pkg::S_IDLE && h_req && !io_en) |=>
      (d_req == '0 && !bm_req && h_done && !h_err && h_rdata == '0));

  p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
    h_err |-> (h_done && h_rdata == '0));

  p_err_no_access_r6: assert property (@(posedge clk) disable iff (rst)
    h_err |-> (d_req == '0 && !bm_req));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    h_done |=> !h_done);

  p_drive_end_done_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(|d_req) |-> h_done);

  p_bm_single_r2: assert property (@(posedge clk) disable iff (rst)
    bm_req |=> (!bm_req && h_done));
endmodule

bind drive_access_router dar_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .io_en(io_en), .h_req(h_req), .st(st),
  .d_req(d_req), .bm_req(bm_req), .h_done(h_done), .h_err(h_err),
  .h_rdata(h_rdata)
);

// File: tb/sim_drive_access_router.sv
module sim_drive_access_router;
  localparam int AW = 16;
  localparam int OW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic io_en, bar_wr, h_req, h_wr;
  logic [2:0] bar_idx, h_size;
  logic [AW-1:0] bar_val, h_addr;
  logic [5*AW-1:0] win_size;
  logic [31:0] h_wdata, h_rdata, bm_wdata, bm_rdata;
  logic h_done, h_err, d_wr, d_blk, bm_req, bm_wr, bm_chan;
  logic [3:0] d_present, d_req;
  logic [OW-1:0] d_off, bm_off;
  logic [DW-1:0] d_wdata;
  logic [4*DW-1:0] d_rdata;
  logic [2:0] bm_size;

  drive_access_router #(.AW(AW), .OW(OW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .io_en(io_en), .bar_wr(bar_wr), .bar_idx(bar_idx),
    .bar_val(bar_val), .win_size(win_size), .h_req(h_req), .h_wr(h_wr),
    .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata), .h_done(h_done),
    .h_err(h_err), .h_rdata(h_rdata), .d_present(d_present), .d_req(d_req),
    .d_wr(d_wr), .d_blk(d_blk), .d_off(d_off), .d_wdata(d_wdata),
    .d_rdata(d_rdata), .bm_req(bm_req), .bm_wr(bm_wr), .bm_chan(bm_chan),
    .bm_off(bm_off), .bm_size(bm_size), .bm_wdata(bm_wdata),
    .bm_rdata(bm_rdata)
  );

  int nchk = 0, nfail = 0;
  int sizes[5] = '{8, 4, 8, 4, 16};
  logic [15:0] rb[5];
  logic rsel[2];

  // drive models: read value changes with every access seen
  logic [7:0] cnt[4];
  for (genvar i = 0; i < 4; i++) begin : g_drv
    assign d_rdata[i*DW +: DW] = {4'hD, 2'(i), 2'b00, cnt[i]};
  end

  int lg_n, bm_n;
  int lg_idx[4];
  logic lg_wr[4], lg_blk[4];
  logic [OW-1:0] lg_off[4];
  logic [15:0] lg_wd[4], lg_rd[4];
  logic lb_chan, lb_wr;
  logic [OW-1:0] lb_off;
  logic [2:0] lb_size;
  logic [31:0] lb_wd;

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rst) cnt[i] = 8'h00;
      else if (d_req[i]) begin
        cnt[i] = cnt[i] + 8'd1;
        if (lg_n < 4) begin
          lg_idx[lg_n] = i; lg_wr[lg_n] = d_wr; lg_blk[lg_n] = d_blk;
          lg_off[lg_n] = d_off; lg_wd[lg_n] = d_wdata;
          lg_rd[lg_n] = {4'hD, 2'(i), 2'b00, cnt[i]};
        end
        lg_n++;
      end
    end
    if (bm_req) begin
      bm_n++; lb_chan = bm_chan; lb_wr = bm_wr; lb_off = bm_off;
      lb_size = bm_size; lb_wd = bm_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_dec(input logic [15:0] a, output bit hit,
                                  output int w, output int off);
    hit = 0; w = 0; off = 0;
    for (int i = 0; i < 5; i++)
      if (!hit && {1'b0, a} >= {1'b0, rb[i]} &&
          {1'b0, a} < {1'b0, rb[i]} + 17'(sizes[i])) begin
        hit = 1; w = i; off = int'(a - rb[i]);
      end
  endfunction

  task automatic bar(input int idx, input logic [15:0] v);
    @(negedge clk); #1;
    bar_wr = 1; bar_idx = 3'(idx); bar_val = v;
    @(negedge clk); #1;
    bar_wr = 0;
    if (v != 0) rb[idx] = v;   // R9: zero leaves the base alone
  endtask

  task automatic acc(input bit wr, input logic [15:0] a, input logic [2:0] sz,
                     input logic [31:0] wd);
    bit hit, err, bm, szok, cmd, data;
    int w, off, ch, idx, n, lat, got;
    logic [31:0] exp_rd;
    err = 0; bm = 0; n = 0; lat = 1; exp_rd = 0; idx = 0; ch = 0; w = 0; off = 0;
    if (io_en) begin
      ref_dec(a, hit, w, off);
      if (!hit) err = 1;
      else begin
        bm = (w == 4);
        cmd = !bm && (w % 2 == 0);
        data = cmd && off == 0;
        if (data) szok = (sz == 2 || sz == 4);
        else if (bm) szok = (sz == 1 || sz == 2 || sz == 4);
        else szok = (sz == 1);
        if (!szok) begin err = 1; bm = 0; end
        else if (bm) begin lat = 2; ch = (off >= 8); end
        else begin
          ch = w / 2;
          if (cmd && wr && off == 6) rsel[ch] = wd[4];   // R3
          idx = 2 * ch + int'(rsel[ch]);
          if (d_present[idx]) begin n = (sz == 4) ? 2 : 1; lat = n + 1; end
        end
      end
    end
    lg_n = 0; bm_n = 0;
    bm_rdata = $urandom;
    @(negedge clk); #1;
    h_req = 1; h_wr = wr; h_addr = a; h_size = sz; h_wdata = wd;
    got = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); #1;
      h_req = 0;
      if (h_done) begin got = k; break; end
    end
    chk(got == lat, "R11 done latency", 32'(got), 32'(lat));
    chk(h_err == err, err ? "R10/R6 error flag" : "R1 no error", 32'(h_err), 32'(err));
    chk(lg_n == n, io_en ? "R7/R5 drive access count" : "R8 no access", 32'(lg_n), 32'(n));
    chk(bm_n == int'(bm), "R2 bus-master access count", 32'(bm_n), 32'(bm));
    if (bm && bm_n == 1) begin
      chk(lb_chan == 1'(ch) && lb_off == OW'(off) && lb_wr == wr && lb_size == sz &&
          (!wr || lb_wd == wd), "R2 bus-master fields",
          {lb_chan, lb_wr, lb_off}, {1'(ch), wr, OW'(off)});
      if (!wr) chk(h_rdata == bm_rdata, "R2 bus-master read", h_rdata, bm_rdata);
    end
    for (int j = 0; j < n && j < lg_n; j++) begin
      chk(lg_idx[j] == idx && lg_wr[j] == wr && lg_blk[j] == 1'(w % 2) &&
          lg_off[j] == OW'(off), "R4/R1 drive routing",
          32'(lg_idx[j] * 256 + int'(lg_off[j])), 32'(idx * 256 + off));
      if (wr) chk(lg_wd[j] == (j == 0 ? wd[15:0] : wd[31:16]), "R5 write half order",
                  32'(lg_wd[j]), 32'(j == 0 ? wd[15:0] : wd[31:16]));
    end
    if (!wr && !bm) begin
      if (n == 1 && lg_n == 1) exp_rd = (sz == 1) ? 32'(lg_rd[0][7:0]) : 32'(lg_rd[0]);
      if (n == 2 && lg_n == 2) exp_rd = {lg_rd[1], lg_rd[0]};
      chk(h_rdata == exp_rd, n == 0 ? "R7/R10 zero read" : "R5 read data", h_rdata, exp_rd);
    end
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] a;
    int r, s;
    void'($urandom(32'd11));
    io_en = 1; bar_wr = 0; bar_idx = 0; bar_val = 0; h_req = 0; h_wr = 0;
    h_addr = 0; h_size = 1; h_wdata = 0; d_present = 4'b1111; bm_rdata = 0;
    for (int i = 0; i < 5; i++) begin
      win_size[i*AW +: AW] = 16'(sizes[i]); rb[i] = 16'h0;
    end
    rsel[0] = 0; rsel[1] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(h_done == 0 && h_err == 0 && d_req == 0 && bm_req == 0, "R11 reset outputs",
        {h_done, h_err, d_req, bm_req}, 0);
    // R9: reset bases are 0, so address 2 lands in primary command window
    acc(0, 16'h0002, 1, 0);
    bar(0, 16'h01F0); bar(1, 16'h03F4); bar(2, 16'h0170); bar(3, 16'h0374);
    bar(4, 16'hC000);
    // R9: a zero value must not move the base
    bar(0, 16'h0000);
    acc(0, 16'h01F2, 1, 0);
    acc(0, 16'h0002, 1, 0);
    // R3: reset select 0, then select drive 1 and write data through it
    acc(0, 16'h01F0, 2, 0);
    acc(1, 16'h01F6, 1, 32'h10);
    acc(1, 16'h01F0, 4, 32'hBEEF_1234);
    acc(0, 16'h01F0, 4, 0);
    acc(1, 16'h0176, 1, 32'h10);
    acc(0, 16'h0175, 1, 0);
    // R7: absent drive 3
    d_present = 4'b0111;
    acc(0, 16'h0170, 4, 0);
    acc(1, 16'h0170, 2, 32'h55AA);
    d_present = 4'b1111;
    // R6: size errors, no select change
    acc(0, 16'h01F0, 1, 0);
    acc(1, 16'h01F6, 2, 32'h0);
    acc(0, 16'h03F5, 4, 0);
    acc(0, 16'hC001, 3, 0);
    // R2: bus-master split edges
    acc(0, 16'hC007, 1, 0);
    acc(1, 16'hC008, 4, 32'hCAFE_0001);
    acc(0, 16'hC00F, 2, 0);
    // R10: miss
    acc(0, 16'h5000, 1, 0);
    acc(0, 16'h01F8, 1, 0);
    // R8: decode off, select write has no effect
    io_en = 0;
    acc(1, 16'h01F6, 1, 32'h00);
    acc(0, 16'h01F0, 2, 0);
    io_en = 1;
    acc(0, 16'h01F0, 2, 0);
    // R1: priority when primary control overlaps primary command
    bar(1, 16'h01F4);
    acc(0, 16'h01F5, 1, 0);
    acc(0, 16'h01F9, 1, 0);
    bar(1, 16'h03F4);
    for (int t = 0; t < 400; t++) begin
      r = $urandom % 6;
      if (r < 5) a = rb[r] + 16'($urandom % (sizes[r] + 2));
      else a = 16'($urandom);
      s = $urandom % 8;
      if (t % 25 == 24) io_en = ~io_en;
      if (t % 17 == 0) d_present = 4'($urandom);
      acc(1'($urandom), a, (s < 4) ? 3'd1 : (s < 6) ? 3'd2 : (s < 7) ? 3'd4 : 3'd3,
          $urandom);
    end
    io_en = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule